// File: doc/BRIEF.md
# MIDI Port with UART-Mode Byte Interface

This block gives a host processor a byte-wide, two-address window onto a serial MIDI link. One address carries data in both directions. The other takes command bytes on write and returns a status byte on read. Outgoing bytes pass through a one-byte holding register into a transmit shifter. Incoming serial bytes land in a one-byte receive holding register. The serial link runs at a baud rate that is derived by dividing the system clock.

After reset the port is in its default command mode. In that mode MIDI data is neither sent nor captured, and the port accepts only two commands. Command 0x3F switches the port into UART mode, where bytes pass straight through. Command 0xFF returns the port to its default state. Each accepted command places the acknowledge byte 0xFE in the receive holding register, so the host sees it exactly like an incoming byte.

Two level outputs tell an interrupt controller that the transmit holding register is empty and that a received byte is waiting. A sticky overrun output records that a waiting byte was overwritten before the host read it.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, the status byte reads 0x80, `midi_tx` idles high, `irq_tx_empty` is 1, and both `irq_rx_ready` and `rx_overrun` are 0.
- R2: Writing command 0xFF has the following effects on the next cycle:
  - the port leaves UART mode;
  - the transmit holding register is emptied;
  - `rx_overrun` is cleared;
  - the receive holding register holds the acknowledge byte 0xFE.

  A frame that is already on the wire still completes.
- R3: Writing command 0x3F outside UART mode enters UART mode and queues 0xFE. The same command written while already in UART mode is ignored and queues nothing.
- R4: Any other command byte is ignored: there is no acknowledge and no change to the status byte.
- R5: Status bit 7 is 0 exactly while a byte waits in the receive holding register. A data read returns that byte, and bit 7 reads 1 on the next cycle. Reading status has no side effect.
- R6: Status bit 6 is 0 while the transmit holding register is empty.
  - In UART mode, a data write fills the holding register, and bit 6 reads 1 on the next cycle.
  - A data write made while the holding register is full is dropped.
- R7: Each transmitted frame has the following layout, with every bit lasting CLK_HZ/BAUD clocks:
  - one start bit at 0;
  - 8 data bits, least significant bit first;
  - one stop bit at 1.

  `midi_tx` is high whenever no frame is being sent.
- R8: A received frame with a valid stop bit, arriving in UART mode, is stored in the receive holding register. A frame whose stop bit is 0 is discarded, and the receiver resumes on the next falling edge of the line. Frames that arrive outside UART mode are discarded.
- R9: A byte arriving while the receive holding register is full overwrites it and sets `rx_overrun`. The flag stays set until command 0xFF is written.
- R10: `irq_tx_empty` is 1 exactly while the transmit holding register is empty. `irq_rx_ready` is 1 exactly while a received byte or acknowledge waits.
- R11: Data writes made outside UART mode are ignored and produce no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Host write strobe, one cycle per byte |
| cpu_rd | input | 1 | Host read strobe, one cycle per byte |
| cpu_sel_ctl | input | 1 | 0 selects data, 1 selects command (write) or status (read) |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Status byte or receive holding byte, combinational on `cpu_sel_ctl` |
| midi_tx | output | 1 | Serial MIDI output |
| midi_rx | input | 1 | Serial MIDI input, asynchronous |
| irq_tx_empty | output | 1 | Transmit holding register empty |
| irq_rx_ready | output | 1 | Received byte or acknowledge waiting |
| rx_overrun | output | 1 | Sticky overrun indication |

## Verification
Most wrong internal states in this block show up at the status byte on the cycle after the host access that caused them:
- A mode flag stuck in the wrong state appears as an acknowledge where none belongs, or a missing one.
- A holding register that fails to empty or to fill shows in the same way.

A fault in the shifter or in the bit counter shows only on the serial line, one frame time later. That is why a monitor decodes every frame and matches it against the bytes the host wrote. Dropped writes and flushed holding bytes are proved absent by waiting a full frame time with nothing expected.

// File: rtl/midi_uart_port.sv
module midi_uart_port #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 31_250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic       cpu_sel_ctl,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  output logic       midi_tx,
  input  logic       midi_rx,
  output logic       irq_tx_empty,
  output logic       irq_rx_ready,
  output logic       rx_overrun
);
  localparam int DIV = CLK_HZ / BAUD;
  localparam int CW  = $clog2(DIV);
  localparam logic [CW-1:0] BIT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID_LAST = CW'(DIV / 2 - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;

  logic          uart_mode;
  logic          tx_full, tx_busy, tx_line;
  logic [7:0]    tx_hold;
  logic [8:0]    tx_sh;
  logic [3:0]    tx_bit;
  logic [CW-1:0] tx_cnt;
  logic          rx_s1, rx_s2, rx_s3, rx_busy;
  logic [3:0]    rx_bit;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh, rx_hold;
  logic          rx_full, ovr;

  logic cmd_wr, do_reset, do_enter, ack, dat_wr, dat_rd;
  logic rx_tick, rx_done, deliver, keep;

  assign cmd_wr   = cpu_wr & cpu_sel_ctl;
  assign do_reset = cmd_wr && (cpu_wdata == CMD_RESET);
  assign do_enter = cmd_wr && (cpu_wdata == CMD_UART) && !uart_mode;
  assign ack      = do_reset | do_enter;
  assign dat_wr   = cpu_wr && !cpu_sel_ctl && uart_mode && !tx_full;
  assign dat_rd   = cpu_rd && !cpu_sel_ctl;
  assign rx_tick  = rx_busy && (rx_cnt == ((rx_bit == 4'd0) ? MID_LAST : BIT_LAST));
  assign rx_done  = rx_tick && (rx_bit == 4'd9);
  assign deliver  = rx_done && rx_s2 && uart_mode;
  assign keep     = rx_full && !dat_rd && !do_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        uart_mode <= 1'b0;
    else if (do_reset) uart_mode <= 1'b0;
    else if (do_enter) uart_mode <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
      tx_busy <= 1'b0;
      tx_line <= 1'b1;
      tx_sh   <= '1;
      tx_bit  <= '0;
      tx_cnt  <= '0;
    end else begin
      if (!tx_busy) begin
        if (tx_full && !do_reset) begin
          tx_busy <= 1'b1;
          tx_sh   <= {1'b1, tx_hold};
          tx_line <= 1'b0;
          tx_bit  <= '0;
          tx_cnt  <= '0;
          tx_full <= 1'b0;
        end
      end else if (tx_cnt == BIT_LAST) begin
        tx_cnt <= '0;
        if (tx_bit == 4'd9) begin
          tx_busy <= 1'b0;
        end else begin
          tx_line <= tx_sh[0];
          tx_sh   <= {1'b1, tx_sh[8:1]};
          tx_bit  <= tx_bit + 4'd1;
        end
      end else begin
        tx_cnt <= tx_cnt + ONE;
      end
      if (do_reset) tx_full <= 1'b0;
      else if (dat_wr) begin
        tx_full <= 1'b1;
        tx_hold <= cpu_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_s3   <= 1'b1;
      rx_busy <= 1'b0;
      rx_bit  <= '0;
      rx_cnt  <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s1 <= midi_rx;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
      if (!rx_busy) begin
        if (rx_s3 && !rx_s2) begin
          rx_busy <= 1'b1;
          rx_bit  <= '0;
          rx_cnt  <= '0;
        end
      end else if (rx_tick) begin
        rx_cnt <= '0;
        if (rx_bit == 4'd0) begin
          if (rx_s2) rx_busy <= 1'b0;
          else       rx_bit  <= 4'd1;
        end else if (rx_bit == 4'd9) begin
          rx_busy <= 1'b0;
        end else begin
          rx_sh  <= {rx_s2, rx_sh[7:1]};
          rx_bit <= rx_bit + 4'd1;
        end
      end else begin
        rx_cnt <= rx_cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_hold <= '0;
      ovr     <= 1'b0;
    end else begin
      rx_full <= ack | deliver | keep;
      if (ack)          rx_hold <= ACK_BYTE;
      else if (deliver) rx_hold <= rx_sh;
      ovr <= (ovr && !do_reset) | ((ack | deliver) && keep) | (ack && deliver);
    end
  end

  assign cpu_rdata    = cpu_sel_ctl ? {~rx_full, tx_full, 6'b0} : rx_hold;
  assign midi_tx      = tx_line;
  assign irq_tx_empty = ~tx_full;
  assign irq_rx_ready = rx_full;
  assign rx_overrun   = ovr;
endmodule

// File: rtl/midi_uart_port_chk.sv
module midi_uart_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       cpu_sel_ctl,
  input logic [7:0] cpu_wdata,
  input logic       midi_tx,
  input logic       irq_tx_empty,
  input logic       irq_rx_ready,
  input logic       rx_overrun,
  input logic       uart_mode,
  input logic       tx_busy
);
  assert_reset_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_sel_ctl && cpu_wdata == 8'hFF) |=> (irq_rx_ready && !rx_overrun && irq_tx_empty && !uart_mode));

  assert_enter_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && cpu_wr && cpu_sel_ctl && cpu_wdata == 8'h3F) |=> (uart_mode && irq_rx_ready));

  assert_other_cmd_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && !irq_rx_ready && cpu_wr && cpu_sel_ctl && cpu_wdata != 8'hFF && cpu_wdata != 8'h3F)
    |=> !irq_rx_ready);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_sel_ctl && !uart_mode) |=> !irq_rx_ready);

  assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_tx_empty && tx_busy && cpu_wr && !cpu_sel_ctl) |=> !irq_tx_empty);

  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> midi_tx);

  assert_no_rx_outside_uart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && !irq_rx_ready && !(cpu_wr && cpu_sel_ctl)) |=> !irq_rx_ready);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !(cpu_wr && cpu_sel_ctl && cpu_wdata == 8'hFF)) |=> rx_overrun);

  assert_data_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && irq_tx_empty && cpu_wr && !cpu_sel_ctl) |=> irq_tx_empty);
endmodule

bind midi_uart_port midi_uart_port_chk u_chk (.*);

// File: tb/sim_midi_uart_port.sv
`timescale 1ns/1ps
module sim_midi_uart_port;
  localparam int BT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel_ctl = 1'b1, midi_rx = 1'b1;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic midi_tx, irq_tx_empty, irq_rx_ready, rx_overrun;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  midi_uart_port #(.CLK_HZ(1_000_000), .BAUD(31_250)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel_ctl(cpu_sel_ctl),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .midi_tx(midi_tx), .midi_rx(midi_rx),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ready(irq_rx_ready), .rx_overrun(rx_overrun));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic status_is(input string req, input logic [7:0] exp);
    #1 chk(req, cpu_rdata, exp);
  endtask

  task automatic wr(input logic sel, input logic [7:0] b);
    @(negedge clk);
    cpu_sel_ctl = sel; cpu_wdata = b; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_sel_ctl = 1'b1;
  endtask

  task automatic rd_data(input string req, input logic [7:0] exp);
    @(negedge clk);
    cpu_sel_ctl = 1'b0; cpu_rd = 1'b1;
    #1 chk(req, cpu_rdata, exp);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_sel_ctl = 1'b1;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop_ok);
    @(negedge clk);
    midi_rx = 1'b0;
    repeat (BT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_rx = b[i];
      repeat (BT) @(negedge clk);
    end
    midi_rx = stop_ok;
    repeat (BT) @(negedge clk);
    midi_rx = 1'b1;
    repeat (BT) @(negedge clk);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (12 * BT) @(negedge clk);
    chk("R7 all frames sent", 8'(exp_q.size()), 8'd0);
  endtask

  initial begin
    logic [7:0] got, want;
    wait (rst_n);
    forever begin
      @(negedge midi_tx);
      repeat (BT / 2) @(negedge clk);
      chk("R7 start bit", {7'd0, midi_tx}, 8'd0);
      for (int i = 0; i < 8; i++) begin
        repeat (BT) @(negedge clk);
        got[i] = midi_tx;
      end
      repeat (BT) @(negedge clk);
      chk("R7 stop bit", {7'd0, midi_tx}, 8'd1);
      if (exp_q.size() == 0) chk("R7 unexpected frame", got, 8'hxx);
      else begin
        want = exp_q.pop_front();
        chk("R7 frame byte", got, want);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10 reset state
    status_is("R1 status", 8'h80);
    chk("R1 tx idle", {7'd0, midi_tx}, 8'd1);
    chk("R10 tx empty", {7'd0, irq_tx_empty}, 8'd1);
    chk("R10 rx ready", {7'd0, irq_rx_ready}, 8'd0);
    chk("R1 overrun", {7'd0, rx_overrun}, 8'd0);
    // R11 data ignored outside UART mode
    wr(1'b0, 8'h55);
    status_is("R11 status", 8'h80);
    repeat (12 * BT) @(negedge clk);
    // R4 unknown command
    wr(1'b1, 8'h80);
    status_is("R4 status", 8'h80);
    // R3 enter UART mode
    wr(1'b1, 8'h3F);
    status_is("R3 ack pending", 8'h00);
    rd_data("R3 ack byte", 8'hFE);
    status_is("R5 cleared after read", 8'h80);
    status_is("R5 status read no effect", 8'h80);
    wr(1'b1, 8'h3F);
    status_is("R3 repeat ignored", 8'h80);
    // R6 / R7 transmit
    exp_q.push_back(8'hA5);
    wr(1'b0, 8'hA5);
    status_is("R6 holding full", 8'hC0);
    @(negedge clk);
    status_is("R6 moved to shifter", 8'h80);
    exp_q.push_back(8'h3C);
    wr(1'b0, 8'h3C);
    chk("R10 tx not empty", {7'd0, irq_tx_empty}, 8'd0);
    wr(1'b0, 8'h99);
    status_is("R6 still full", 8'hC0);
    drain();
    exp_q.push_back(8'h00);
    wr(1'b0, 8'h00);
    exp_q.push_back(8'hFF);
    wr(1'b0, 8'hFF);
    drain();
    // R8 receive
    send_rx(8'h6B, 1'b1);
    chk("R10 rx ready", {7'd0, irq_rx_ready}, 8'd1);
    status_is("R5 byte waiting", 8'h00);
    rd_data("R8 byte 6B", 8'h6B);
    send_rx(8'h80, 1'b1);
    rd_data("R8 byte 80", 8'h80);
    send_rx(8'h12, 1'b0);
    status_is("R8 bad stop discarded", 8'h80);
    send_rx(8'h34, 1'b1);
    rd_data("R8 recovery byte", 8'h34);
    chk("R9 no overrun yet", {7'd0, rx_overrun}, 8'd0);
    // R9 overrun
    send_rx(8'h11, 1'b1);
    send_rx(8'h22, 1'b1);
    chk("R9 overrun set", {7'd0, rx_overrun}, 8'd1);
    rd_data("R9 newest kept", 8'h22);
    chk("R9 overrun sticky", {7'd0, rx_overrun}, 8'd1);
    // R2 reset command with a frame in flight
    exp_q.push_back(8'h5A);
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'h77);
    wr(1'b1, 8'hFF);
    status_is("R2 ack and holding flushed", 8'h00);
    chk("R2 overrun cleared", {7'd0, rx_overrun}, 8'd0);
    rd_data("R2 ack byte", 8'hFE);
    drain();
    wr(1'b0, 8'h44);
    status_is("R2 left UART mode", 8'h80);
    send_rx(8'h33, 1'b1);
    status_is("R8 outside UART mode", 8'h80);
    drain();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule